// File: doc/BRIEF.md
# Deferred error syndrome capture register

This block is a 64-bit status register that records the fact that a pending asynchronous system error was absorbed by an error-synchronization barrier instead of being raised as an exception. When the barrier executes, a one-cycle event arrives on the barrier port. The event carries a pending-error flag, a format selector and a 24-bit syndrome. If an error was pending, the register is loaded with a "deferred" flag and the syndrome. Software can also read and write the register directly through a plain read/write port.

Two syndrome layouts share the low bits, and the format bit picks between them. With the fixed layout, only named fields survive: a write-update code, an error type, an abort type, the write-not-read pair and a fault status code. With the free-form layout, all 24 low bits are kept. Two configuration pins shape the layout. One states whether the extended error-reporting fields exist. The other states whether any error sources exist that a barrier can synchronize; without them the deferred flag stays zero. Reserved bits are forced to zero on every store, whether it comes from a barrier capture or from a software write.

The barrier event port (`bar_valid`) is a valid-only input. The register takes every event in the cycle it is presented, so the port never applies back-pressure. The read result port (`rd_valid`/`rd_data`) is also valid-only. It has no ready input, and the consumer must take each result in the cycle it appears.

Top module: `defer_syn_reg`

## Requirements
- R1: After reset, the stored value is zero, so a read returns 64'h0. `rd_valid` is low while `rst_n` is low.
- R2: Bits 63:32 and bits 30:25 always read as zero, whatever is captured or written.
- R3: When a barrier event (`bar_valid`=1) has `bar_pending`=1, the whole register is replaced. Bit 31 (the deferred flag) is set to 1, bit 24 takes `bar_free_fmt`, and the low bits take the masked `bar_syndrome`.
- R4: A barrier event with `bar_pending`=0 leaves the register unchanged.
- R5: When bit 24 is 0 (fixed layout), only these low bits are kept:
  - bits 17:16 (write-update code);
  - bits 12:10 (error type);
  - bit 9 (abort type);
  - bit 7 (write-not-read valid);
  - bit 6 (write-not-read);
  - bits 5:0 (fault status code).

  Bits 23:18, 15:13 and 8 read as zero.
- R6: When bit 24 is 1 (free-form layout), all of bits 23:0 are kept as given.
- R7: When `cfg_ext_report`=0, bits 17:16, 7 and 6 read as zero in the fixed layout.
- R8: When `cfg_sync_src`=0, bit 31 reads as zero after any capture or write.
- R9: A software write (`sw_wr_en`=1) stores `sw_wr_data` masked by the layout selected by `sw_wr_data[24]` and by the configuration pins.
- R10: When a capture with a pending error and a software write fall in the same cycle, the capture value is stored and the write is dropped.
- R11: A read issued with `sw_rd_en`=1 in cycle t returns `rd_valid`=1 in cycle t+1, with `rd_data` equal to the value stored at the end of cycle t. This includes any update made in cycle t itself. In a cycle after a cycle without `sw_rd_en`, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ext_report | input | 1 | Extended error-reporting fields present |
| cfg_sync_src | input | 1 | Barrier-synchronizable error sources present |
| bar_valid | input | 1 | Barrier event this cycle |
| bar_pending | input | 1 | A pending asynchronous error is deferred |
| bar_free_fmt | input | 1 | Syndrome uses the free-form layout |
| bar_syndrome | input | 24 | Syndrome bundle carried by the event |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write data |
| sw_rd_en | input | 1 | Software read request |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |

## Verification
The functions that collide are a barrier capture and a software write in the same cycle, and an update and a software read in the same cycle. The bench drives a pending capture and a write with different data in one cycle, then reads and expects the capture value. It also issues reads in the very cycle of a write or a capture, and judges the value that comes back one cycle later against the updated model. Each returned word is compared by a scoreboard against a model built only from the masks stated in the requirements.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int REG_W    = 64;
  localparam int SYN_W    = 24;
  localparam int LIVE_W   = 32;
  localparam int FLAG_BIT = 31;
  localparam int FMT_BIT  = 24;
  localparam int WU_HI    = 17;
  localparam int WU_LO    = 16;
  localparam int AET_HI   = 12;
  localparam int AET_LO   = 10;
  localparam int EA_BIT   = 9;
  localparam int WNRV_BIT = 7;
  localparam int WNR_BIT  = 6;
  localparam int FSC_HI   = 5;

  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/dsr_mask_gen.sv
module dsr_mask_gen
  import dsr_pkg::*;
(
  input  logic  free_fmt,
  input  logic  ext_report,
  input  logic  sync_src,
  output word_t mask
);
  always_comb begin
    mask = '0;
    mask[FLAG_BIT] = sync_src;
    mask[FMT_BIT]  = 1'b1;
    if (free_fmt) begin
      mask[SYN_W-1:0] = '1;
    end else begin
      mask[AET_HI:AET_LO] = '1;
      mask[EA_BIT]        = 1'b1;
      mask[FSC_HI:0]      = '1;
      if (ext_report) begin
        mask[WU_HI:WU_LO] = '1;
        mask[WNRV_BIT]    = 1'b1;
        mask[WNR_BIT]     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsr_store.sv
module dsr_store #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_comb begin
    nxt = q;
    if (cap_en)     nxt = cap_val;
    else if (wr_en) nxt = wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && wr_en) |=> (q == $past(cap_val)));  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_en) |=> $stable(q));  // R4
endmodule

// File: rtl/dsr_rd_port.sv
module dsr_rd_port #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic [W-1:0] fwd_val,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= fwd_val;
    end
  end

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);  // R11
endmodule

// File: rtl/defer_syn_reg.sv
module defer_syn_reg
  import dsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_report,
  input  logic             cfg_sync_src,
  input  logic             bar_valid,
  input  logic             bar_pending,
  input  logic             bar_free_fmt,
  input  logic [SYN_W-1:0] bar_syndrome,
  input  logic             sw_wr_en,
  input  logic [REG_W-1:0] sw_wr_data,
  input  logic             sw_rd_en,
  output logic             rd_valid,
  output logic [REG_W-1:0] rd_data
);
  word_t cap_mask, wr_mask, cap_raw, st_nxt, st_q;
  logic  cap_en;

  assign cap_en = bar_valid && bar_pending;

  always_comb begin
    cap_raw            = '0;
    cap_raw[FLAG_BIT]  = 1'b1;
    cap_raw[FMT_BIT]   = bar_free_fmt;
    cap_raw[SYN_W-1:0] = bar_syndrome;
  end

  dsr_mask_gen u_cap_mask (
    .free_fmt   (bar_free_fmt),
    .ext_report (cfg_ext_report),
    .sync_src   (cfg_sync_src),
    .mask       (cap_mask)
  );

  dsr_mask_gen u_wr_mask (
    .free_fmt   (sw_wr_data[FMT_BIT]),
    .ext_report (cfg_ext_report),
    .sync_src   (cfg_sync_src),
    .mask       (wr_mask)
  );

  dsr_store #(.W(REG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_val (cap_raw & cap_mask),
    .wr_en   (sw_wr_en),
    .wr_val  (sw_wr_data & wr_mask),
    .nxt     (st_nxt),
    .q       (st_q)
  );

  dsr_rd_port #(.W(REG_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (sw_rd_en),
    .fwd_val  (st_nxt),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[REG_W-1:LIVE_W] == '0) && (st_q[30:25] == '0));  // R2
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cfg_sync_src) |=> st_q[FLAG_BIT]);  // R3
  AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_en || sw_wr_en) && !cfg_sync_src) |=> !st_q[FLAG_BIT]);  // R8
  AST_FIXED_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q[FMT_BIT] |-> (st_q[23:18] == '0 && st_q[15:13] == '0 && !st_q[8]));  // R5
  AST_READ_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_en |=> (rd_valid && rd_data == st_q));  // R11
endmodule

// File: tb/test_defer_syn_reg.sv
`timescale 1ns/1ps
module test_defer_syn_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ext_report = 1'b1, cfg_sync_src = 1'b1;
  logic        bar_valid = 1'b0, bar_pending = 1'b0, bar_free_fmt = 1'b0;
  logic [23:0] bar_syndrome = '0;
  logic        sw_wr_en = 1'b0, sw_rd_en = 1'b0;
  logic [63:0] sw_wr_data = '0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int errors = 0, checks = 0;
  logic [63:0] model = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  defer_syn_reg i_defer_syn_reg (
    .clk, .rst_n, .cfg_ext_report, .cfg_sync_src, .bar_valid, .bar_pending,
    .bar_free_fmt, .bar_syndrome, .sw_wr_en, .sw_wr_data, .sw_rd_en,
    .rd_valid, .rd_data
  );

  function automatic logic [63:0] keep_mask(logic fmt, logic ext, logic sync);
    logic [63:0] m;
    m = fmt ? 64'h0000_0000_81FF_FFFF :
        (ext ? 64'h0000_0000_8103_1EFF : 64'h0000_0000_8100_1E3F);
    if (!sync) m[31] = 1'b0;
    return m;
  endfunction

  task automatic op(input logic cap, input logic pend, input logic fmt,
                    input logic [23:0] syn, input logic wr,
                    input logic [63:0] wd, input logic rd, input string tag);
    bar_valid = cap; bar_pending = pend; bar_free_fmt = fmt; bar_syndrome = syn;
    sw_wr_en = wr; sw_wr_data = wd; sw_rd_en = rd;
    if (cap && pend)
      model = {32'h0, 1'b1, 6'h0, fmt, syn} & keep_mask(fmt, cfg_ext_report, cfg_sync_src);
    else if (wr)
      model = wd & keep_mask(wd[24], cfg_ext_report, cfg_sync_src);
    if (rd) begin
      exp_q.push_back(model);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    bar_valid = 1'b0; sw_wr_en = 1'b0; sw_rd_en = 1'b0;
  endtask

  task automatic rd_only(input string tag);
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b0, 64'h0, 1'b1, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected rd_valid: got %h expected no result", rd_data);
      end else begin
        automatic logic [63:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++; $display("FAIL R1 rd_valid in reset: got %b expected 0", rd_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    rd_only("R1 reset value");
    // R3 R5 fixed capture with ext fields
    op(1'b1, 1'b1, 1'b0, 24'hFF_FFFF, 1'b0, 64'h0, 1'b0, "");
    rd_only("R3/R5 fixed capture");
    // R6 free-form capture replaces old contents
    op(1'b1, 1'b1, 1'b1, 24'hA5_A5A5, 1'b0, 64'h0, 1'b0, "");
    rd_only("R6 free capture");
    // R4 barrier without pending
    op(1'b1, 1'b0, 1'b0, 24'h12_3456, 1'b0, 64'h0, 1'b0, "");
    rd_only("R4 no pending hold");
    // R7 ext fields absent
    cfg_ext_report = 1'b0;
    op(1'b1, 1'b1, 1'b0, 24'hFF_FFFF, 1'b0, 64'h0, 1'b0, "");
    rd_only("R7 ext fields zero");
    // R9 software writes, both layouts
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 64'hFFFF_FFFF_FEFF_FFFF, 1'b0, "");
    rd_only("R9 write fixed layout");
    cfg_ext_report = 1'b1;
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, "");
    rd_only("R9 write fixed ext");
    // R2 upper and 30:25 bits dropped on write
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "");
    rd_only("R2 reserved zero on write");
    // R8 no sync sources
    cfg_sync_src = 1'b0;
    op(1'b1, 1'b1, 1'b1, 24'h00_0F0F, 1'b0, 64'h0, 1'b0, "");
    rd_only("R8 capture flag zero");
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 64'h8100_00FF, 1'b0, "");
    rd_only("R8 write flag zero");
    cfg_sync_src = 1'b1;
    // R10 simultaneous capture and write
    op(1'b1, 1'b1, 1'b0, 24'h00_1C21, 1'b1, 64'h81FF_FFFF, 1'b0, "");
    rd_only("R10 capture wins");
    // R4 no-pending event with write: write applies
    op(1'b1, 1'b0, 1'b1, 24'h00_0000, 1'b1, 64'h0100_0042, 1'b0, "");
    rd_only("R4 write with idle barrier");
    // R11 forwarding of a same-cycle write and capture
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 64'h8133_3333, 1'b1, "R11 write forwarded");
    op(1'b1, 1'b1, 1'b0, 24'h03_0A5C, 1'b0, 64'h0, 1'b1, "R11 capture forwarded");
    op(1'b0, 1'b0, 1'b0, 24'h0, 1'b0, 64'h0, 1'b0, "");
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++; $display("FAIL R11 idle rd_valid: got %b expected 0", rd_valid);
    end
    rd_only("R11 back-to-back read 1");
    rd_only("R11 back-to-back read 2");
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R11 missing results: got %0d pending expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule